// File: doc/BRIEF.md
# Dual-Core Mailbox FIFO Pair

This block lets two processors pass 32-bit words to each other through a pair of FIFOs that run in opposite directions. Each processor owns one register port. A write to the port's send address pushes a word into that processor's outgoing FIFO. A read of the port's receive address pops a word from its incoming FIFO. A read of the status address reports whether words are waiting and whether there is room to send. Each port also drives a level signal that is high while words are waiting for it, and this signal can serve as an interrupt request.

A one-bit core identity input on each port picks which of the two FIFOs that port sends into. The port receives from the other FIFO. Illegal accesses are dropped and recorded in two sticky flags per port: one for a write into a full FIFO, one for a read from an empty FIFO. Any write to the status address clears both flags of that port. Both ports may be given the same identity. In that case they share one view, and in a cycle where both touch the same FIFO, port 0 wins and port 1's access is treated as refused.

Top module: `mbx_pair`

## Requirements
- R1: After reset, a status read on either port returns 0x00000002 (word-present bit 0 clear, room bit 1 set, both flags clear), and both `port_avail` bits are 0.
- R2: Words pushed at the send address (address 1) are popped, in the order written, at the receive address (address 2) of the port whose incoming FIFO is the same FIFO.
- R3: Status bit 0 and `port_avail` for a port are 1 exactly when that port's incoming FIFO holds at least one word.
- R4: Status bit 1 is 1 exactly when the port's outgoing FIFO holds fewer than DEPTH words.
- R5: A send-address write while the outgoing FIFO is full stores nothing. It sets status bit 2 of that port, and the bit stays set until cleared.
- R6: A receive-address read while the incoming FIFO is empty returns 0 and leaves the FIFO unchanged. It sets status bit 3 of that port, and the bit stays set until cleared.
- R7: Any write to the status address (address 0) clears bits 2 and 3 of that port only.
- R8: A port whose identity input is c sends into FIFO c and receives from FIFO 1-c.
- R9: When both ports send into the same FIFO in one cycle, only port 0's word is stored and port 1's bit 2 is set. When both receive from the same FIFO in one cycle, port 0 gets the word, port 1 reads 0 and its bit 3 is set.
- R10: Reads of address 1 or 3 return 0. Writes to address 2 or 3 change no FIFO and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_cid | input | 2 | Identity bit per port; bit p belongs to port p |
| port_req | input | 2 | Access strobe per port, one cycle per access |
| port_wr | input | 2 | 1 = write, 0 = read, per port |
| port_addr | input | 2x2 | Register address per port: 0 status, 1 send, 2 receive, 3 unused |
| port_wdata | input | 2x32 | Write data per port |
| port_rdata | output | 2x32 | Combinational read data per port |
| port_avail | output | 2 | High while the port's incoming FIFO is non-empty |

## Verification
The bench builds the block with DEPTH = 4, so every fill level from empty to one beyond full can be swept in both directions in a few dozen cycles. At each level it checks status bits, the availability signal and the popped order against a queue model. The small depth also keeps the refused-write and empty-read paths, the per-port flag clearing, the identity remapping and the same-cycle contention between ports all within a short run.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int WORD_W = 32;
    localparam int NPORT  = 2;

    typedef enum logic [1:0] {
        REG_STAT = 2'd0,
        REG_TXD  = 2'd1,
        REG_RXD  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic roe;   // bit 3: read while empty
        logic wof;   // bit 2: write while full
        logic rdy;   // bit 1: room to send
        logic vld;   // bit 0: word waiting
    } stat_t;

    function automatic logic [WORD_W-1:0] stat_word(stat_t s);
        return {{(WORD_W-4){1'b0}}, s};
    endfunction

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_ptr] <= din;
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok)
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH)); // R4
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> full); // R5
    AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (empty && !push) |=> (empty && $stable(rd_ptr))); // R6

endmodule

// File: rtl/mbx_port.sv
module mbx_port
    import mbx_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req,
    input  logic         wr,
    input  logic [1:0]   addr,
    input  logic         tx_full,
    input  logic         rx_empty,
    input  logic [W-1:0] rx_head,
    input  logic         tx_lose,
    input  logic         rx_lose,
    output logic         push,
    output logic         pop,
    output logic [W-1:0] rdata,
    output logic         avail
);
    logic  is_txw, is_rxr, is_clr, tx_bad, rx_bad;
    logic  wof_q, roe_q;
    stat_t st;

    assign is_txw = req &&  wr && (addr == REG_TXD);
    assign is_rxr = req && !wr && (addr == REG_RXD);
    assign is_clr = req &&  wr && (addr == REG_STAT);
    assign tx_bad = tx_full  || tx_lose;
    assign rx_bad = rx_empty || rx_lose;
    assign push   = is_txw && !tx_bad;
    assign pop    = is_rxr && !rx_bad;
    assign avail  = !rx_empty;

    always_comb begin
        st.vld = !rx_empty;
        st.rdy = !tx_full;
        st.wof = wof_q;
        st.roe = roe_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wof_q <= 1'b0;
            roe_q <= 1'b0;
        end else if (is_clr) begin
            wof_q <= 1'b0;
            roe_q <= 1'b0;
        end else begin
            if (is_txw && tx_bad) wof_q <= 1'b1;
            if (is_rxr && rx_bad) roe_q <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (req && !wr) begin
            case (addr)
                REG_STAT: rdata = W'(stat_word(st));
                REG_RXD:  rdata = rx_bad ? '0 : rx_head;
                default:  rdata = '0;
            endcase
        end
    end

    AST_WOF_SET: assert property (@(posedge clk) disable iff (rst)
        (is_txw && tx_full) |=> wof_q); // R5
    AST_ROE_SET: assert property (@(posedge clk) disable iff (rst)
        (is_rxr && rx_empty) |=> roe_q); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        ((wof_q || roe_q) && !is_clr) |=> (wof_q || roe_q)); // R5
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        is_clr |=> (!wof_q && !roe_q)); // R7
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (is_rxr && rx_empty) |-> (rdata == '0)); // R6

endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
    import mbx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int W     = WORD_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NPORT-1:0]      port_cid,
    input  logic [NPORT-1:0]      port_req,
    input  logic [NPORT-1:0]      port_wr,
    input  logic [NPORT-1:0][1:0] port_addr,
    input  logic [NPORT-1:0][W-1:0] port_wdata,
    output logic [NPORT-1:0][W-1:0] port_rdata,
    output logic [NPORT-1:0]      port_avail
);
    logic [NPORT-1:0]        f_full, f_empty, f_push, f_pop;
    logic [NPORT-1:0][W-1:0] f_head, f_din;
    logic [NPORT-1:0]        p_push, p_pop, att_tx, att_rx, tx_lose, rx_lose;
    logic                    same_id;

    assign same_id = (port_cid[0] == port_cid[1]);

    // Port 0 has priority when both ports target one FIFO.
    assign tx_lose = {att_tx[0] && same_id, 1'b0};
    assign rx_lose = {att_rx[0] && same_id, 1'b0};

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign att_tx[p] = port_req[p] &&  port_wr[p] && (port_addr[p] == REG_TXD);
        assign att_rx[p] = port_req[p] && !port_wr[p] && (port_addr[p] == REG_RXD);

        mbx_port #(.W(W)) u_port (
            .clk      (clk),
            .rst      (rst),
            .req      (port_req[p]),
            .wr       (port_wr[p]),
            .addr     (port_addr[p]),
            .tx_full  (f_full[port_cid[p]]),
            .rx_empty (f_empty[!port_cid[p]]),
            .rx_head  (f_head[!port_cid[p]]),
            .tx_lose  (tx_lose[p]),
            .rx_lose  (rx_lose[p]),
            .push     (p_push[p]),
            .pop      (p_pop[p]),
            .rdata    (port_rdata[p]),
            .avail    (port_avail[p])
        );
    end

    for (genvar f = 0; f < NPORT; f++) begin : g_fifo
        logic sel0_tx, sel1_tx, sel0_rx, sel1_rx;
        assign sel0_tx = p_push[0] && (port_cid[0] == 1'(f));
        assign sel1_tx = p_push[1] && (port_cid[1] == 1'(f));
        assign sel0_rx = p_pop[0]  && (port_cid[0] != 1'(f));
        assign sel1_rx = p_pop[1]  && (port_cid[1] != 1'(f));
        assign f_push[f] = sel0_tx || sel1_tx;
        assign f_pop[f]  = sel0_rx || sel1_rx;
        assign f_din[f]  = sel0_tx ? port_wdata[0] : port_wdata[1];

        mbx_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (f_push[f]),
            .din   (f_din[f]),
            .pop   (f_pop[f]),
            .head  (f_head[f]),
            .full  (f_full[f]),
            .empty (f_empty[f])
        );

        AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
            $onehot0({sel0_tx, sel1_tx})); // R9
        AST_ONE_READER: assert property (@(posedge clk) disable iff (rst)
            $onehot0({sel0_rx, sel1_rx})); // R9
    end

    AST_AVAIL_MATCH: assert property (@(posedge clk) disable iff (rst)
        port_avail[0] == !f_empty[!port_cid[0]]); // R3

endmodule

// File: tb/mbx_pair_tb.sv
module mbx_pair_tb;
    import mbx_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int W          = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0]        cid = 2'b10;
    logic [1:0]        req = '0;
    logic [1:0]        wr  = '0;
    logic [1:0][1:0]   addr = '0;
    logic [1:0][W-1:0] wdata = '0;
    logic [1:0][W-1:0] rdata;
    logic [1:0]        avail;

    int n_chk = 0;
    int n_bad = 0;
    int q [2][$];
    bit wof_m [2];
    bit roe_m [2];
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_pair #(.DEPTH(DEPTH), .W(W)) u_dut (
        .clk(clk), .rst(rst), .port_cid(cid), .port_req(req), .port_wr(wr),
        .port_addr(addr), .port_wdata(wdata), .port_rdata(rdata), .port_avail(avail)
    );

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] st_exp(int p);
        int tx = int'(cid[p]);
        int rx = 1 - tx;
        return {28'd0, roe_m[p], wof_m[p], q[tx].size() < DEPTH, q[rx].size() != 0};
    endfunction

    // One access on port p, checked against the queue model.
    task automatic acc(string tag, int p, bit w, logic [1:0] a, logic [W-1:0] d);
        logic [W-1:0] exp;
        int tx, rx;
        @(negedge clk);
        tx = int'(cid[p]);
        rx = 1 - tx;
        req[p] = 1'b1; wr[p] = w; addr[p] = a; wdata[p] = d;
        exp = '0;
        if (!w && a == 2'd0) exp = st_exp(p);
        if (!w && a == 2'd2) begin
            if (q[rx].size() > 0) exp = q[rx].pop_front();
            else roe_m[p] = 1;
        end
        if (w && a == 2'd1) begin
            if (q[tx].size() < DEPTH) q[tx].push_back(int'(d));
            else wof_m[p] = 1;
        end
        if (w && a == 2'd0) begin wof_m[p] = 0; roe_m[p] = 0; end
        #1;
        if (!w) chk(tag, rdata[p], exp);
        @(posedge clk);
        #1 req[p] = 1'b0;
    endtask

    task automatic chk_stat(string tag, int p);
        acc(tag, p, 1'b0, 2'd0, '0);
        chk({tag, " avail"}, {31'd0, avail[p]}, {31'd0, q[1 - int'(cid[p])].size() != 0});
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        acc("R1 stat p0", 0, 0, 2'd0, '0);
        acc("R1 stat p1", 1, 0, 2'd0, '0);
        chk("R1 avail", {30'd0, avail}, 32'd0);
        chk("R1 raw stat", st_exp(0), 32'h2);

        // Sweep fill levels in both directions (R2..R7)
        for (int dir = 0; dir < 2; dir++) begin
            for (int n = 0; n <= DEPTH + 1; n++) begin
                int s = dir, r = 1 - dir;
                for (int k = 0; k < n; k++) begin
                    acc(n > DEPTH && k == n - 1 ? "R5 write full" : "R2 write", s, 1, 2'd1,
                        32'hA000_0000 + 32'(dir * 256 + n * 16 + k));
                    chk_stat("R4 sender stat", s);
                    chk_stat("R3 receiver stat", r);
                end
                for (int k = 0; k <= n; k++)
                    acc(k == n || k >= DEPTH ? "R6 read tail" : "R2 order", r, 0, 2'd2, '0);
                chk_stat("R6 receiver stat", r);
                chk_stat("R5 sender stat", s);
                // R7: clear only the sender; receiver keeps its read-empty flag
                acc("R7 clear", s, 1, 2'd0, 32'hFFFF_FFFF);
                chk_stat("R7 cleared port", s);
                chk_stat("R7 other port kept", r);
                acc("R7 clear other", r, 1, 2'd0, '0);
                chk_stat("R7 other cleared", r);
            end
        end

        // R10 unused and wrong-direction addresses
        acc("R10 write rx addr", 0, 1, 2'd2, 32'h1111);
        acc("R10 write addr3", 0, 1, 2'd3, 32'h2222);
        acc("R10 read tx addr", 0, 0, 2'd1, '0);
        acc("R10 read addr3", 0, 0, 2'd3, '0);
        chk_stat("R10 p0 stat", 0);
        chk_stat("R10 p1 stat", 1);

        // R8 swapped identities: port 0 sends into FIFO 1
        cid = 2'b01;
        acc("R8 write", 0, 1, 2'd1, 32'hC0DE_0001);
        chk_stat("R8 p1 sees word", 1);
        chk_stat("R8 p0 no word", 0);
        acc("R8 read", 1, 0, 2'd2, '0);
        // Shared identity: both ports send into FIFO 0
        cid = 2'b00;
        acc("R8 shared w0", 0, 1, 2'd1, 32'h5000_0000);
        acc("R8 shared w1", 1, 1, 2'd1, 32'h5000_0001);
        cid = 2'b10;
        acc("R8 shared r0", 1, 0, 2'd2, '0);
        acc("R8 shared r1", 1, 0, 2'd2, '0);

        // R9 same-cycle contention on one FIFO
        cid = 2'b00;
        @(negedge clk);
        req = 2'b11; wr = 2'b11; addr = {2'd1, 2'd1};
        wdata = {32'hBBBB_0001, 32'hAAAA_0001};
        @(posedge clk); #1 req = 2'b00;
        q[0].push_back(32'hAAAA_0001);
        wof_m[1] = 1;
        chk_stat("R9 p1 wof", 1);
        chk_stat("R9 p0 no wof", 0);
        // Both read FIFO 1 (identity 0 receives FIFO 1): put one word there first
        cid = 2'b11;
        acc("R9 prime", 0, 1, 2'd1, 32'hCCCC_0001);
        cid = 2'b00;
        @(negedge clk);
        req = 2'b11; wr = 2'b00; addr = {2'd2, 2'd2};
        #1;
        chk("R9 p0 gets word", rdata[0], 32'hCCCC_0001);
        chk("R9 p1 reads zero", rdata[1], 32'd0);
        @(posedge clk); #1 req = 2'b00;
        void'(q[1].pop_front());
        roe_m[1] = 1;
        chk_stat("R9 p1 roe", 1);
        cid = 2'b10;
        acc("R9 drain", 1, 0, 2'd2, '0);
        chk_stat("R9 drained", 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule